// File: doc/BRIEF.md
# Seeded Random Word Generator

This peripheral sits on a simple 32-bit register bus and hands out batches of five pseudo-random words. Software first loads five seed words. A seed-written mask records which of them have been loaded. Once all five are present, a write to the control register can start a run, but only if it selects the generator mode and sets the start bit in the same write. The start bit never stays set: every control write stores the value with that bit cleared.

A run loads a 32-bit Galois LFSR with the XOR of the five seed words. The LFSR is then stepped once per clock for five clocks. The five states it passes through are collected in a staging buffer and copied to the output registers together on the last step. During those five clocks the busy flag is high, and the output registers still hold the previous batch. When the batch lands, a generation-done flag is set.

The status register reports these events. Software can overwrite only its three completion flags; all other status bits are kept. Reads return data one clock after they are requested. Offsets that map to no register read as zero, and writes to them are dropped.

Top module: `seedgen_regs`

## Requirements
- R1: After reset, control reads 0x0, status reads 0x01, all five output registers read 0 and the seed-written mask is empty.
- R2: A write to seed register n (byte offset 0x140+4n, n=0..4) marks seed n as written. Status bit 1 becomes 1 only once all five seeds have been written, and stays 0 while any seed is missing.
- R3: A control write (offset 0x0) stores the written value with bit 4 forced to 0. A later read of control returns that value.
- R4: A control write starts a run only if status bit 1 is set, written bit 3 is 1 and written bit 4 is 1. If any of these is missing, busy does not rise and the output registers and status bit 5 keep their values.
- R5: When a run starts, status bit 2 (busy) is 1 for exactly five clocks, beginning at the edge after the control write. The five new output words and status bit 5 appear at the edge where busy falls.
- R6: Output word k (offset 0x160+4k) is the LFSR state after k+1 steps from the seed XOR. One step is next = (s >> 1) XOR (s[0] ? 0x80200003 : 0).
- R7: Reads of the output registers while busy is 1 return the previous batch.
- R8: A status write (offset 0x10) replaces bits 5, 4 and 3 with the written bits and keeps all other bits. If a status write lands on the edge where a run completes, bit 5 still ends up 1.
- R9: Read data is valid one clock after the read request. Reads of unmapped or misaligned offsets return 0, and writes to them change no register.
- R10: If the XOR of the seeds is zero, the LFSR starts from 0x00000001 instead.
- R11: A control write that arrives while busy is 1 stores its value (bit 4 cleared) but does not restart or extend the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 9 | Byte offset within the 0x200 window |
| wr_en | input | 1 | Write strobe for one full 32-bit word |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | 32 | Read data, valid one clock after rd_en |

## Verification
Every visible result arrives through a read, and read data appears one edge after the edge that samples rd_en. The bench therefore compares rd_data at the falling edge that follows each read request. A control write that starts a run makes busy visible to a read sampled at the very next edge. The new words and the done flag are visible to reads sampled from the fifth edge after that one. The reference model advances on the same edges as the design, so a read issued mid-run is predicted with the old words. A status write aimed exactly at the completion edge checks how the done flag is resolved when both events hit together.

// File: rtl/seedgen_regs.sv
module seedgen_regs #(
  parameter int          WORDS     = 5,
  parameter int          AW        = 9,
  parameter logic [31:0] TAPS      = 32'h8020_0003,
  parameter logic [31:0] ZERO_FILL = 32'h0000_0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic          rd_en,
  output logic [31:0]   rd_data
);
  localparam int IW = $clog2(WORDS);
  localparam logic [AW-1:0] A_CTRL = AW'('h000);
  localparam logic [AW-1:0] A_STAT = AW'('h010);
  localparam logic [AW-1:0] A_SEED = AW'('h140);
  localparam logic [AW-1:0] A_OUT  = AW'('h160);

  logic [31:0]      ctrl_q;
  logic [31:0]      seed_q  [WORDS];
  logic [31:0]      stage_q [WORDS];
  logic [31:0]      out_q   [WORDS];
  logic [31:0]      lfsr_q;
  logic [WORDS-1:0] mask_q;
  logic             seed_done_q;
  logic             busy_q;
  logic [2:0]       flag_q;
  logic [IW-1:0]    step_q;

  logic [AW-1:0] seed_off, out_off;
  logic          seed_hit, out_hit;
  logic [IW-1:0] seed_idx, out_idx;

  assign seed_off = addr - A_SEED;
  assign out_off  = addr - A_OUT;
  assign seed_hit = (addr[1:0] == 2'b00) && (addr >= A_SEED) && (int'(seed_off) < 4 * WORDS);
  assign out_hit  = (addr[1:0] == 2'b00) && (addr >= A_OUT) && (int'(out_off) < 4 * WORDS);
  assign seed_idx = seed_off[IW+1:2];
  assign out_idx  = out_off[IW+1:2];

  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? TAPS : 32'h0);
  endfunction

  logic [31:0] seed_xor;
  always_comb begin
    seed_xor = '0;
    for (int i = 0; i < WORDS; i++) seed_xor = seed_xor ^ seed_q[i];
  end

  logic [31:0] lfsr_nx;
  assign lfsr_nx = lfsr_step(lfsr_q);

  logic wr_ctrl, wr_stat, wr_seed, go;
  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_stat = wr_en && (addr == A_STAT);
  assign wr_seed = wr_en && seed_hit;
  assign go      = wr_ctrl && !busy_q && seed_done_q && wr_data[3] && wr_data[4];

  logic [WORDS-1:0] seed_bit;
  assign seed_bit = wr_seed ? (WORDS'(1) << seed_idx) : '0;

  logic [31:0] status_word;
  assign status_word = {24'h0, 2'b00, flag_q, busy_q, seed_done_q, 1'b1};

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (addr == A_CTRL)      rd_mux = ctrl_q;
    else if (addr == A_STAT) rd_mux = status_word;
    else if (out_hit)        rd_mux = out_q[out_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      lfsr_q      <= '0;
      mask_q      <= '0;
      seed_done_q <= 1'b0;
      busy_q      <= 1'b0;
      flag_q      <= '0;
      step_q      <= '0;
      rd_data     <= '0;
      for (int i = 0; i < WORDS; i++) begin
        seed_q[i]  <= '0;
        stage_q[i] <= '0;
        out_q[i]   <= '0;
      end
    end else begin
      if (rd_en) rd_data <= rd_mux;
      if (wr_ctrl) ctrl_q <= wr_data & ~32'h10;
      if (wr_stat) flag_q <= wr_data[5:3];
      if (wr_seed) begin
        seed_q[seed_idx] <= wr_data;
        mask_q           <= mask_q | seed_bit;
        seed_done_q      <= &(mask_q | seed_bit);
      end
      if (go) begin
        lfsr_q <= (seed_xor == '0) ? ZERO_FILL : seed_xor;
        busy_q <= 1'b1;
        step_q <= '0;
      end
      if (busy_q) begin
        lfsr_q          <= lfsr_nx;
        stage_q[step_q] <= lfsr_nx;
        step_q          <= step_q + 1'b1;
        if (step_q == IW'(WORDS - 1)) begin
          busy_q    <= 1'b0;
          flag_q[2] <= 1'b1;
          for (int i = 0; i < WORDS - 1; i++) out_q[i] <= stage_q[i];
          out_q[WORDS-1] <= lfsr_nx;
        end
      end
    end
  end
endmodule

// File: rtl/seedgen_regs_chk.sv
module seedgen_regs_chk #(
  parameter int WORDS = 5,
  parameter int AW    = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [31:0]   ctrl_q,
  input logic          busy_q,
  input logic          seed_done_q,
  input logic [2:0]    flag_q,
  input logic [31:0]   out_first,
  input logic [31:0]   out_last
);
  int busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_len <= 0;
    else if (busy_q) busy_len <= busy_len + 1;
    else             busy_len <= 0;
  end

  a_r3_start_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0) |=> !ctrl_q[4]);

  a_r4_no_run_without_seeds: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !seed_done_q) |=> !busy_q);

  a_r2_seed_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    seed_done_q |=> seed_done_q);

  a_r7_outputs_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> ($stable(out_first) && $stable(out_last)));

  a_r5_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> busy_len < WORDS);

  a_r5_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> flag_q[2]);
endmodule

bind seedgen_regs seedgen_regs_chk #(.WORDS(WORDS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .ctrl_q(ctrl_q), .busy_q(busy_q), .seed_done_q(seed_done_q), .flag_q(flag_q),
  .out_first(out_q[0]), .out_last(out_q[WORDS-1])
);

// File: tb/tb_seedgen_regs.sv
module tb_seedgen_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;

  seedgen_regs dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
                    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit fin = 1'b0;
  string cur_tag = "";

  // Behavioural reference model
  logic [31:0] m_ctrl, m_rd;
  logic [31:0] m_seed [5];
  logic [31:0] m_out  [5];
  logic [31:0] m_pend [5];
  bit   [4:0]  m_mask;
  bit          m_sd, m_done, m_msg, m_part, rd_chk;
  int          m_cnt;

  function automatic logic [31:0] gen_word(input logic [31:0] x, input int k);
    logic [31:0] s = (x == 0) ? 32'h1 : x;
    for (int j = 0; j <= k; j++) s = (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
    return s;
  endfunction

  function automatic logic [31:0] model_read(input logic [8:0] a);
    if (a == 9'h000) return m_ctrl;
    if (a == 9'h010) return {24'h0, 2'b00, m_done, m_msg, m_part, (m_cnt > 0), m_sd, 1'b1};
    for (int n = 0; n < 5; n++) if (a == 9'h160 + 9'(4 * n)) return m_out[n];
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= 0; m_rd <= 0; m_mask <= 0; m_sd <= 0; m_cnt <= 0;
      m_done <= 0; m_msg <= 0; m_part <= 0; rd_chk <= 0;
      for (int n = 0; n < 5; n++) begin m_seed[n] <= 0; m_out[n] <= 0; m_pend[n] <= 0; end
    end else begin
      rd_chk <= rd_en;
      if (rd_en) m_rd <= model_read(addr);
      if (wr_en && addr == 9'h000) begin
        m_ctrl <= wr_data & ~32'h10;
        if (m_cnt == 0 && m_sd && wr_data[3] && wr_data[4]) begin
          logic [31:0] x;
          x = m_seed[0] ^ m_seed[1] ^ m_seed[2] ^ m_seed[3] ^ m_seed[4];
          for (int n = 0; n < 5; n++) m_pend[n] <= gen_word(x, n);
          m_cnt <= 5;
        end
      end
      if (wr_en && addr == 9'h010) {m_done, m_msg, m_part} <= wr_data[5:3];
      for (int n = 0; n < 5; n++)
        if (wr_en && addr == 9'h140 + 9'(4 * n)) begin
          bit [4:0] nm;
          nm = m_mask | (5'b1 << n);
          m_seed[n] <= wr_data;
          m_mask    <= nm;
          m_sd      <= (nm == 5'h1f);
        end
      if (m_cnt > 0) begin
        m_cnt <= m_cnt - 1;
        if (m_cnt == 1) begin
          for (int n = 0; n < 5; n++) m_out[n] <= m_pend[n];
          m_done <= 1'b1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && rd_chk) begin
      checks++;
      if (rd_data !== m_rd) begin
        fails++;
        $display("FAIL %s: got %08h expected %08h", cur_tag, rd_data, m_rd);
      end
    end
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, input string tag);
    @(negedge clk); addr = a; rd_en = 1'b1; cur_tag = tag;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(20 * 100000);
    if (!fin) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(9'h000, "R1 control");
    rd(9'h010, "R1 status");
    for (int n = 0; n < 5; n++) rd(9'h160 + 9'(4 * n), "R1 output");
    // R4 start without seeds, R3 stored value with start bit cleared
    wr(9'h000, 32'h18);
    rd(9'h010, "R4 status no seeds");
    rd(9'h000, "R3 control readback");
    rd(9'h160, "R4 output unchanged");
    // R2 seed tracking
    wr(9'h140, 32'h1234_5678); wr(9'h144, 32'h0bad_f00d);
    wr(9'h148, 32'hcafe_0001); wr(9'h14c, 32'h7777_aaaa);
    rd(9'h010, "R2 partial seeds");
    wr(9'h150, 32'h0f0f_3c3c);
    rd(9'h010, "R2 all seeds");
    // R4 missing mode / missing start
    wr(9'h000, 32'h10); rd(9'h010, "R4 no mode");
    wr(9'h000, 32'h08); rd(9'h010, "R4 no start"); rd(9'h000, "R3 control mode only");
    // R5 / R7 run
    wr(9'h000, 32'h18);
    rd(9'h160, "R7 old word during busy");
    rd(9'h010, "R5 busy set");
    repeat (6) @(negedge clk);
    rd(9'h010, "R5 done after run");
    for (int n = 0; n < 5; n++) rd(9'h160 + 9'(4 * n), "R6 output word");
    // R8 status write masking
    wr(9'h010, 32'h0); rd(9'h010, "R8 clear flags");
    wr(9'h010, 32'hffff_ffff); rd(9'h010, "R8 set flags");
    // R9 unmapped and misaligned
    rd(9'h100, "R9 unmapped read");
    rd(9'h162, "R9 misaligned read");
    wr(9'h104, 32'hffff_ffff); wr(9'h002, 32'h5);
    rd(9'h000, "R9 ignored writes");
    rd(9'h1fc, "R9 top of window");
    // R10 zero seed XOR
    wr(9'h140, 32'haaaa_5555); wr(9'h144, 32'haaaa_5555);
    wr(9'h148, 32'h1357_9bdf); wr(9'h14c, 32'h1357_9bdf); wr(9'h150, 32'h0);
    wr(9'h000, 32'h18);
    // R11 control write during busy
    wr(9'h000, 32'h1c);
    rd(9'h010, "R11 still busy");
    rd(9'h000, "R11 control stored");
    repeat (6) @(negedge clk);
    for (int n = 0; n < 5; n++) rd(9'h160 + 9'(4 * n), "R10 zero seed word");
    rd(9'h010, "R11 idle after single run");
    // R8 status write on completion edge
    wr(9'h010, 32'h0);
    wr(9'h000, 32'h18);
    repeat (3) @(negedge clk);
    wr(9'h010, 32'h0);
    rd(9'h010, "R8 done wins at completion");
    rd(9'h164, "R6 word after rerun");
    repeat (2) @(negedge clk);
    fin = 1'b1;
    summary();
    $finish;
  end
endmodule